// File: doc/BRIEF.md
# DRAM Bus Efficiency Monitor

This block sits beside a DDR3 memory interface and measures how much of the memory clock is spent moving data. It takes decoded strobes for the Activate command and for read-data and write-data beats, and it counts nothing until the calibration-done input has been seen high. After that it waits for the first Activate. That Activate opens a measurement window, and the window stays open until a stop pulse. Inside the window the block keeps four saturating counters: every cycle, cycles carrying any data, cycles carrying read data, and cycles carrying write data.

When the window closes, three sequential dividers that share the total-cycle count as their denominator produce unsigned Q0.16 fractions for combined, read-only and write-only efficiency. A final multiply scales a configured peak bandwidth, in MB/s, by the combined fraction to give effective bandwidth. The results hold until a clear pulse or a restart pulse.

The controller runs as a five-state machine. WAIT_CAL goes to ARMED when calibration done is high. ARMED goes to MEASURE on an Activate, or straight to DIVIDE when stop arrives together with that Activate. MEASURE goes to DIVIDE on stop. DIVIDE goes to DONE when the quotients are ready. DONE goes back to ARMED on start. A clear in any state returns the machine to WAIT_CAL.

Top module: `dram_eff_monitor`

## Requirements
- R1: While in WAIT_CAL, the Activate and data strobes have no effect. The state leaves WAIT_CAL on the edge that samples `cal_done` high, and an Activate in that same cycle is ignored.
- R2: In ARMED, data strobes are ignored. The first `cmd_act` opens the window, and `window_open` is high from the next cycle until the window closes.
- R3: The total counter advances once per cycle, starting with the Activate cycle and ending with the cycle before the stop pulse. The stop cycle itself is not counted.
- R4: The data counter advances on window cycles that carry `rd_data_vld` or `wr_data_vld`. Separate read and write counters advance on their own strobe.
- R5: `eff_all`, `eff_rd` and `eff_wr` equal floor(count × 65536 / total), capped at 0xFFFF. They are valid while `result_done` is high, and `result_done` holds until a start or a clear.
- R6: `eff_bw` equals floor(`peak_mbps` × `eff_all` / 65536).
- R7: If stop arrives in the same cycle as the opening Activate, total is zero and no division is run. `result_done` rises with every efficiency and `eff_bw` at zero.
- R8: Counters stop at their all-ones value instead of wrapping. `cnt_overflow` goes high and stays high until the counters are next cleared.
- R9: Reset and a `mon_clear` pulse return the block to WAIT_CAL with all counters and results at zero, `window_open` low and `result_done` low.
- R10: `mon_start` while `result_done` is high zeroes the results and returns to ARMED, so the next Activate opens a new window without calibration being seen again.
- R11: A stop pulse outside an open window has no effect. In ARMED it neither opens a window nor produces a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low reset |
| cal_done | input | 1 | Calibration complete |
| mon_clear | input | 1 | Synchronous clear to WAIT_CAL |
| mon_start | input | 1 | Restart from DONE into ARMED |
| mon_stop | input | 1 | Closes the measurement window |
| cmd_act | input | 1 | Decoded Activate command |
| rd_data_vld | input | 1 | Read data on the bus this cycle |
| wr_data_vld | input | 1 | Write data on the bus this cycle |
| peak_mbps | input | 32 | Peak bandwidth in MB/s |
| eff_all | output | 16 | Combined efficiency, Q0.16 |
| eff_rd | output | 16 | Read efficiency, Q0.16 |
| eff_wr | output | 16 | Write efficiency, Q0.16 |
| eff_bw | output | 32 | Effective bandwidth in MB/s |
| window_open | output | 1 | Measurement window active |
| result_done | output | 1 | Results valid |
| cnt_overflow | output | 1 | A counter saturated |

## Verification
A state machine that arms early, or opens the window on a stray strobe, raises `window_open` one cycle after the offending input. A counter that is off by one, or that counts the stop cycle, shows up in the Q0.16 results as soon as `result_done` rises, because a short window turns a one-cycle error into a large change in the fraction. A divider or product fault shows up in the same cycle as the result, and a saturation fault shows up as a wrong `cnt_overflow` value or as a result below 0xFFFF on a window that is saturated with data.

// File: rtl/dbe_pkg.sv
package dbe_pkg;
    typedef enum logic [2:0] {
        ST_WAIT_CAL,
        ST_ARMED,
        ST_MEASURE,
        ST_DIVIDE,
        ST_DONE
    } mon_state_e;

    localparam int NUM_CNT = 4;
    localparam int CI_TOT  = 0;
    localparam int CI_DAT  = 1;
    localparam int CI_RD   = 2;
    localparam int CI_WR   = 3;
    localparam int NUM_DIV = NUM_CNT - 1;
endpackage

// File: rtl/dbe_sat_cnt.sv
module dbe_sat_cnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         ovf
);
    localparam logic [W-1:0] MAX = '1;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (inc) begin
            if (cnt == MAX) ovf <= 1'b1;
            else            cnt <= cnt + 1'b1;
        end
    end

    // R8
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAX && !clr) |=> (cnt == MAX));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr) |=> ovf);
endmodule

// File: rtl/dbe_frac_div.sv
module dbe_frac_div #(
    parameter int W = 32,
    parameter int F = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         busy,
    output logic         done,
    output logic [F-1:0] quo
);
    localparam int IW = $clog2(F + 1);

    logic [W:0]    rem_q;
    logic [W:0]    rem_sh;
    logic [W:0]    rem_nx;
    logic [W-1:0]  den_q;
    logic [IW-1:0] it_q;
    logic          ge;

    always_comb begin
        rem_sh = {rem_q[W-1:0], 1'b0};
        ge     = (rem_sh >= {1'b0, den_q});
        rem_nx = ge ? (rem_sh - {1'b0, den_q}) : rem_sh;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            den_q <= '0;
            it_q  <= '0;
            quo   <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                quo  <= '0;
                it_q <= '0;
                if (den == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    rem_q <= {1'b0, num};
                    den_q <= den;
                    busy  <= 1'b1;
                end
            end else if (busy) begin
                rem_q <= rem_nx;
                quo   <= {quo[F-2:0], ge};
                it_q  <= it_q + 1'b1;
                if (it_q == IW'(F - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // R5
    div_num_le_den_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (num <= den));

    // R5
    div_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/dram_eff_monitor.sv
module dram_eff_monitor
    import dbe_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int FRAC_W = 16,
    parameter int BW_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_done,
    input  logic              mon_clear,
    input  logic              mon_start,
    input  logic              mon_stop,
    input  logic              cmd_act,
    input  logic              rd_data_vld,
    input  logic              wr_data_vld,
    input  logic [BW_W-1:0]   peak_mbps,
    output logic [FRAC_W-1:0] eff_all,
    output logic [FRAC_W-1:0] eff_rd,
    output logic [FRAC_W-1:0] eff_wr,
    output logic [BW_W-1:0]   eff_bw,
    output logic              window_open,
    output logic              result_done,
    output logic              cnt_overflow
);
    localparam int PW = BW_W + FRAC_W;

    mon_state_e state_q, state_nx;

    logic [CNT_W-1:0]   cnt [NUM_CNT];
    logic [NUM_CNT-1:0] inc;
    logic [NUM_CNT-1:0] ovf;
    logic               cnt_clr;
    logic               in_win;
    logic               div_go;
    logic [FRAC_W-1:0]  div_quo [NUM_DIV];
    logic [NUM_DIV-1:0] div_done;
    logic [NUM_DIV-1:0] div_busy;
    logic [PW-1:0]      bw_prod;
    logic               res_clr;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT_CAL;
        else        state_q <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_WAIT_CAL: if (cal_done)    state_nx = ST_ARMED;
            ST_ARMED:    if (cmd_act)     state_nx = mon_stop ? ST_DIVIDE : ST_MEASURE;
            ST_MEASURE:  if (mon_stop)    state_nx = ST_DIVIDE;
            ST_DIVIDE:   if (div_done[0]) state_nx = ST_DONE;
            ST_DONE:     if (mon_start)   state_nx = ST_ARMED;
            default:                      state_nx = ST_WAIT_CAL;
        endcase
        if (mon_clear) state_nx = ST_WAIT_CAL;
    end

    // window qualification
    always_comb begin
        in_win = !mon_clear && !mon_stop &&
                 ((state_q == ST_ARMED && cmd_act) || state_q == ST_MEASURE);
        div_go = !mon_clear && mon_stop &&
                 ((state_q == ST_ARMED && cmd_act) || state_q == ST_MEASURE);
        cnt_clr = mon_clear || state_q == ST_WAIT_CAL ||
                  (state_q == ST_DONE && mon_start);
        res_clr = cnt_clr;
        inc[CI_TOT] = in_win;
        inc[CI_DAT] = in_win && (rd_data_vld || wr_data_vld);
        inc[CI_RD]  = in_win && rd_data_vld;
        inc[CI_WR]  = in_win && wr_data_vld;
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        dbe_sat_cnt #(.W(CNT_W)) cnt_i (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (cnt_clr),
            .inc  (inc[g]),
            .cnt  (cnt[g]),
            .ovf  (ovf[g])
        );
    end

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
        dbe_frac_div #(.W(CNT_W), .F(FRAC_W)) div_i (
            .clk  (clk),
            .rst_n(rst_n),
            .go   (div_go),
            .num  (cnt[g + 1]),
            .den  (cnt[CI_TOT]),
            .busy (div_busy[g]),
            .done (div_done[g]),
            .quo  (div_quo[g])
        );
    end

    assign bw_prod = {{FRAC_W{1'b0}}, peak_mbps} * {{BW_W{1'b0}}, div_quo[0]};

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n || res_clr) begin
            eff_all <= '0;
            eff_rd  <= '0;
            eff_wr  <= '0;
            eff_bw  <= '0;
        end else if (state_q == ST_DIVIDE && div_done[0]) begin
            eff_all <= div_quo[0];
            eff_rd  <= div_quo[1];
            eff_wr  <= div_quo[2];
            eff_bw  <= bw_prod[PW-1:FRAC_W];
        end
    end

    assign window_open  = (state_q == ST_MEASURE);
    assign result_done  = (state_q == ST_DONE);
    assign cnt_overflow = |ovf;

    // R4
    data_le_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt[CI_DAT] <= cnt[CI_TOT]);

    // R4
    dir_le_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt[CI_RD] <= cnt[CI_DAT]) && (cnt[CI_WR] <= cnt[CI_DAT]));

    // R1
    wait_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_CAL) |=> (cnt[CI_TOT] == '0));

    // R3
    window_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MEASURE && !mon_stop && !mon_clear && cnt[CI_TOT] != '1)
        |=> (cnt[CI_TOT] == $past(cnt[CI_TOT]) + 1'b1));

    // R5
    busy_in_divide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_busy != '0) |-> (state_q == ST_DIVIDE));
endmodule

// File: tb/dram_eff_monitor_tb.sv
module dram_eff_monitor_tb_top;
    localparam int CW  = 12;
    localparam int MAXC = (1 << CW) - 1;
    localparam int NV  = 5;
    // len, read cycles, write cycles, peak MB/s
    localparam int unsigned VEC [NV][4] = '{
        '{20,  10,  5,   12800},
        '{16,  16,  0,   6400},
        '{7,   0,   3,   1000},
        '{1,   1,   0,   25600},
        '{300, 97,  150, 3200}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cal_done = 0, mon_clear = 0, mon_start = 0, mon_stop = 0;
    logic cmd_act = 0, rd_data_vld = 0, wr_data_vld = 0;
    logic [31:0] peak_mbps = 32'd1000;
    logic [15:0] eff_all, eff_rd, eff_wr;
    logic [31:0] eff_bw;
    logic window_open, result_done, cnt_overflow;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dram_eff_monitor #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cal_done(cal_done), .mon_clear(mon_clear),
        .mon_start(mon_start), .mon_stop(mon_stop), .cmd_act(cmd_act),
        .rd_data_vld(rd_data_vld), .wr_data_vld(wr_data_vld), .peak_mbps(peak_mbps),
        .eff_all(eff_all), .eff_rd(eff_rd), .eff_wr(eff_wr), .eff_bw(eff_bw),
        .window_open(window_open), .result_done(result_done), .cnt_overflow(cnt_overflow)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic longint frac(input int unsigned n, input int unsigned d);
        longint q;
        if (d == 0) return 0;
        q = (longint'(n) << 16) / longint'(d);
        return (q > 65535) ? 65535 : q;
    endfunction

    function automatic int unsigned sat(input int unsigned v);
        return (v > MAXC) ? MAXC : v;
    endfunction

    task automatic pulse_clear();
        @(negedge clk) mon_clear = 1'b1;
        @(negedge clk) mon_clear = 1'b0;
    endtask

    task automatic arm();
        @(negedge clk) cal_done = 1'b1;
        @(negedge clk) cal_done = 1'b0; rd_data_vld = 1'b1; wr_data_vld = 1'b1;
        @(negedge clk);
        chk("R2 strobes before activate", window_open, 0);
        rd_data_vld = 1'b0; wr_data_vld = 1'b0;
    endtask

    task automatic run_window(input int len, input int nrd, input int nwr);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (i == 1) chk("R2 window open after activate", window_open, 1);
            cmd_act     = (i == 0);
            rd_data_vld = (i < nrd);
            wr_data_vld = (i >= nrd) && (i < nrd + nwr);
        end
        @(negedge clk);
        cmd_act = 0; rd_data_vld = 0; wr_data_vld = 0; mon_stop = 1'b1;
        @(negedge clk) mon_stop = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!result_done && n < 64) begin
            @(negedge clk);
            n++;
        end
        chk(tag, result_done, 1);
    endtask

    task automatic check_results(input int len, input int nrd, input int nwr);
        int unsigned t = sat(len);
        int unsigned dd = sat(nrd + nwr);
        longint ea = frac(dd, t);
        chk("R5 eff_all", eff_all, ea);
        chk("R4 R5 eff_rd", eff_rd, frac(sat(nrd), t));
        chk("R4 R5 eff_wr", eff_wr, frac(sat(nwr), t));
        chk("R6 eff_bw", eff_bw, (longint'(peak_mbps) * ea) >> 16);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 reset window_open", window_open, 0);
        chk("R9 reset result_done", result_done, 0);
        chk("R9 reset eff_all", eff_all, 0);
        chk("R9 reset overflow", cnt_overflow, 0);
        rst_n = 1'b1;

        // R1: activity before calibration is ignored
        @(negedge clk) cmd_act = 1; rd_data_vld = 1;
        @(negedge clk) cmd_act = 0; rd_data_vld = 0;
        @(negedge clk);
        chk("R1 activate before cal", window_open, 0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            peak_mbps = VEC[v][3];
            pulse_clear();
            arm();
            run_window(VEC[v][0], VEC[v][1], VEC[v][2]);
            if (VEC[v][0] == 1) chk("R3 window closed", window_open, 0);
            wait_done("R5 result_done");
            check_results(VEC[v][0], VEC[v][1], VEC[v][2]);
            chk("R8 no overflow", cnt_overflow, 0);
        end

        // R10: restart from DONE without recalibration
        @(negedge clk) mon_start = 1'b1;
        @(negedge clk) mon_start = 1'b0;
        chk("R10 done cleared", result_done, 0);
        chk("R10 results zeroed", eff_all, 0);
        run_window(10, 0, 10);
        wait_done("R10 result after restart");
        check_results(10, 0, 10);

        // R11: stop in ARMED has no effect
        peak_mbps = 32'd8000;
        pulse_clear();
        arm();
        @(negedge clk) mon_stop = 1'b1;
        @(negedge clk) mon_stop = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 stop in armed window", window_open, 0);
        chk("R11 stop in armed result", result_done, 0);
        run_window(8, 2, 2);
        wait_done("R11 result");
        check_results(8, 2, 2);

        // R7: zero-length window
        pulse_clear();
        arm();
        @(negedge clk) cmd_act = 1; mon_stop = 1;
        @(negedge clk) cmd_act = 0; mon_stop = 0;
        wait_done("R7 result_done");
        chk("R7 eff_all zero", eff_all, 0);
        chk("R7 eff_wr zero", eff_wr, 0);
        chk("R7 eff_bw zero", eff_bw, 0);

        // R9: clear mid-window
        pulse_clear();
        arm();
        @(negedge clk) cmd_act = 1; rd_data_vld = 1;
        @(negedge clk) cmd_act = 0;
        @(negedge clk) mon_clear = 1;
        @(negedge clk) mon_clear = 0; rd_data_vld = 0;
        chk("R9 clear closes window", window_open, 0);
        chk("R9 clear result", result_done, 0);
        @(negedge clk) cmd_act = 1;
        @(negedge clk) cmd_act = 0;
        chk("R9 R1 activate after clear", window_open, 0);

        // R8: saturation
        peak_mbps = 32'd1000;
        pulse_clear();
        arm();
        run_window(MAXC + 100, MAXC + 100, 0);
        wait_done("R8 result_done");
        chk("R8 overflow flag", cnt_overflow, 1);
        check_results(MAXC + 100, MAXC + 100, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule